// File: doc/BRIEF.md
# Masked Device Interrupt Router

This block keeps a routing table for a set of device interrupt sources behind a 64-bit register interface. Each source owns two registers. The routing register names the target CPU and the vector to deliver. The control register holds a mask flag and a pending flag. When a source fires while its mask is clear, the block latches the event and arms both flags. It then issues a one-cycle post that carries the stored CPU id and vector to the CPU delivery fabric. Because acceptance sets the mask, the source stays silent until software clears the pending flag and unmasks it again.

Software reaches the two register arrays through a simple request/response port. Each array packs one 64-bit entry per source at an 8-byte pitch. Several sources can be accepted in the same cycle. In that case they wait in a request latch and are posted one per cycle, lowest source number first. An access to any address outside the two arrays returns zero and raises an error strobe.

Top module: `irq_route_top`

## Requirements
- R1: After reset every source reads back routing value zero (CPU 0, vector 0) and control value 0x4 (mask set, pending clear).
- R2: A routing register keeps the CPU id from write-data bits 12:8 and the vector from bits 5:0. It reads back those fields in the same positions, and every other bit reads as zero.
- R3: A control register reads with the mask flag in bit 2, the pending flag in bit 0, and zero elsewhere. A write loads the mask from write-data bit 2.
- R4: A control write with bit 1 set clears the pending flag. With bit 1 clear, the pending flag is unchanged.
- R5: A device interrupt that arrives while its source's mask is set is ignored. No post follows it, and the source's pending flag is not changed by it.
- R6: A device interrupt that arrives while its source's mask is clear sets both mask and pending. If the request latch was empty, the block asserts post_valid on the next cycle for one cycle, with that source's stored CPU id and vector.
- R7: Sources accepted in the same cycle, or while earlier ones are still waiting, are posted one per cycle in ascending source order. Each accepted event is posted exactly once.
- R8: Routing entries start at offset 0x000 and control entries at offset 0x200, with 8 bytes per entry. The source index is the offset into the array shifted right by 3, and address bits 2:0 are ignored.
- R9: A read or write outside both arrays returns read data zero, pulses rsp_err with the response, and changes no state.
- R10: Every request produces exactly one response cycle, with rsp_valid high on the cycle after the request. Writes return read data zero.
- R11: When a control write and an accepted interrupt for the same source fall in the same cycle, the acceptance wins: mask and pending both end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Unmapped-offset error strobe |
| rsp_rdata | output | 64 | Read data |
| dev_irq | input | 8 | One interrupt event line per source |
| post_valid | output | 1 | One-cycle interrupt post to the CPU fabric |
| post_cpu | output | 5 | Target CPU id of the post |
| post_vec | output | 6 | Vector of the post |

## Verification
The hardest state to reach from the ports is a crowded request latch. This is the case where several sources are accepted together while older events are still waiting. It can also coincide with software rewriting the control register of a source in the very cycle that source fires. Directed sequences unmask several sources and fire them in one cycle. Another sequence lines up a control write with an interrupt on the same source. A long random phase then keeps many sources unmasked through frequent control writes and fires sparse random patterns, so the latch regularly holds more than one entry. A cycle-level model in the bench predicts each response and each post.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ROUTE = 2'd1,
        SEL_CTRL = 2'd2
    } sel_e;

    // field positions inside the 64-bit registers
    localparam int CPU_LSB   = 8;
    localparam int VEC_LSB   = 0;
    localparam int MASK_BIT  = 2;
    localparam int CLEAR_BIT = 1;
    localparam int PEND_BIT  = 0;

    // entry pitch in bytes is 1 << STRIDE_SH
    localparam int STRIDE_SH = 3;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_SRC    = 8,
    parameter int ROUTE_BASE = 'h000,
    parameter int CTRL_BASE  = 'h200,
    parameter int IDX_W      = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] RB   = ADDR_W'(ROUTE_BASE);
    localparam logic [ADDR_W-1:0] CB   = ADDR_W'(CTRL_BASE);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_SRC << STRIDE_SH);

    logic [ADDR_W-1:0] off_route;
    logic [ADDR_W-1:0] off_ctrl;
    logic              hit_route;
    logic              hit_ctrl;

    always_comb begin
        off_route = addr - RB;
        off_ctrl  = addr - CB;
        hit_route = (addr >= RB) && (off_route < SPAN);
        hit_ctrl  = (addr >= CB) && (off_ctrl < SPAN);
        sel = SEL_NONE;
        idx = '0;
        if (hit_route) begin
            sel = SEL_ROUTE;
            idx = IDX_W'(off_route >> STRIDE_SH);
        end else if (hit_ctrl) begin
            sel = SEL_CTRL;
            idx = IDX_W'(off_ctrl >> STRIDE_SH);
        end
    end
endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     pool,
    output logic             found,
    output logic [IDX_W-1:0] win_idx,
    output logic [N-1:0]     grant
);
    // scan from the top so the lowest set bit is the last one written
    always_comb begin
        found   = |pool;
        win_idx = '0;
        grant   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pool[i]) begin
                win_idx  = IDX_W'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int CPU_W      = 5,
    parameter int VEC_W      = 6,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 64,
    parameter int ROUTE_BASE = 'h000,
    parameter int CTRL_BASE  = 'h200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic [NUM_SRC-1:0] dev_irq,
    output logic               post_valid,
    output logic [CPU_W-1:0]   post_cpu,
    output logic [VEC_W-1:0]   post_vec
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0][CPU_W-1:0] cpu;
        logic [NUM_SRC-1:0][VEC_W-1:0] vec;
        logic [NUM_SRC-1:0]            mask;
        logic [NUM_SRC-1:0]            pend;
        logic [NUM_SRC-1:0]            req;
        logic                          rsp_valid;
        logic                          rsp_err;
        logic [DATA_W-1:0]             rsp_rdata;
        logic                          post_valid;
        logic [CPU_W-1:0]              post_cpu;
        logic [VEC_W-1:0]              post_vec;
    } state_t;

    state_t s_d;
    state_t s_q;

    sel_e               acc_sel;
    logic [IDX_W-1:0]   acc_idx;
    logic [NUM_SRC-1:0] accept;
    logic [NUM_SRC-1:0] pool;
    logic               win_found;
    logic [IDX_W-1:0]   win_idx;
    logic [NUM_SRC-1:0] win_grant;
    logic               unused_wdata;

    assign unused_wdata = ^req_wdata;

    irq_route_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_SRC    (NUM_SRC),
        .ROUTE_BASE (ROUTE_BASE),
        .CTRL_BASE  (CTRL_BASE),
        .IDX_W      (IDX_W)
    ) u_decode (
        .addr (req_addr),
        .sel  (acc_sel),
        .idx  (acc_idx)
    );

    assign accept = dev_irq & ~s_q.mask;
    assign pool   = s_q.req | accept;

    irq_route_arb #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_arb (
        .pool    (pool),
        .found   (win_found),
        .win_idx (win_idx),
        .grant   (win_grant)
    );

    always_comb begin
        s_d = s_q;

        // register access, answered on the next cycle
        s_d.rsp_valid = req_valid;
        s_d.rsp_err   = 1'b0;
        s_d.rsp_rdata = '0;
        if (req_valid) begin
            case (acc_sel)
                SEL_ROUTE: begin
                    if (req_write) begin
                        s_d.cpu[acc_idx] = req_wdata[CPU_LSB +: CPU_W];
                        s_d.vec[acc_idx] = req_wdata[VEC_LSB +: VEC_W];
                    end else begin
                        s_d.rsp_rdata[CPU_LSB +: CPU_W] = s_q.cpu[acc_idx];
                        s_d.rsp_rdata[VEC_LSB +: VEC_W] = s_q.vec[acc_idx];
                    end
                end
                SEL_CTRL: begin
                    if (req_write) begin
                        s_d.mask[acc_idx] = req_wdata[MASK_BIT];
                        if (req_wdata[CLEAR_BIT]) begin
                            s_d.pend[acc_idx] = 1'b0;
                        end
                    end else begin
                        s_d.rsp_rdata[MASK_BIT] = s_q.mask[acc_idx];
                        s_d.rsp_rdata[PEND_BIT] = s_q.pend[acc_idx];
                    end
                end
                default: begin
                    s_d.rsp_err = 1'b1;
                end
            endcase
        end

        // acceptance overrides a same-cycle control write
        s_d.mask = s_d.mask | accept;
        s_d.pend = s_d.pend | accept;

        // one post per cycle, lowest waiting source first
        s_d.post_valid = win_found;
        s_d.post_cpu   = '0;
        s_d.post_vec   = '0;
        if (win_found) begin
            s_d.post_cpu = s_q.cpu[win_idx];
            s_d.post_vec = s_q.vec[win_idx];
        end
        s_d.req = pool & ~win_grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid  = s_q.rsp_valid;
    assign rsp_err    = s_q.rsp_err;
    assign rsp_rdata  = s_q.rsp_rdata;
    assign post_valid = s_q.post_valid;
    assign post_cpu   = s_q.post_cpu;
    assign post_vec   = s_q.post_vec;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int NUM_SRC = 8,
    parameter int DATA_W  = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic [NUM_SRC-1:0] dev_irq,
    input logic               post_valid,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] req_q
);
    // R10: one response cycle for each request, one cycle later
    a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9: an error response carries zero data
    a_r9_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // R7: a post needs an accepted or waiting source in the cycle before
    a_r7_post_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |-> $past(|(req_q | (dev_irq & ~mask_q))));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // R6: acceptance arms both flags
        a_r6_accept_arms: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_irq[i] && !mask_q[i]) |=> (mask_q[i] && pend_q[i]));
        // R5: pending only rises through an unmasked event
        a_r5_pend_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[i]) |-> $past(dev_irq[i] && !mask_q[i]));
        // R6: the latch only gains a source through an unmasked event
        a_r6_req_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_q[i]) |-> $past(dev_irq[i] && !mask_q[i]));
    end
endmodule

bind irq_route_top irq_route_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
) u_irq_route_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .dev_irq    (dev_irq),
    .post_valid (post_valid),
    .mask_q     (s_q.mask),
    .pend_q     (s_q.pend),
    .req_q      (s_q.req)
);

// File: tb/test_irq_route_top.sv
module test_irq_route_top;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;
    logic [7:0]  dev_irq = '0;
    logic        post_valid;
    logic [4:0]  post_cpu;
    logic [5:0]  post_vec;

    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R1";

    // reference model state
    logic [4:0] m_cpu [NS];
    logic [5:0] m_vec [NS];
    logic [7:0] m_mask, m_pend, m_req;

    always #10 clk = ~clk;

    irq_route_top i_irq_route_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .dev_irq    (dev_irq),
        .post_valid (post_valid),
        .post_cpu   (post_cpu),
        .post_vec   (post_vec)
    );

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // kind: 0 unmapped, 1 routing array, 2 control array (R8)
    function automatic int decode_kind(logic [11:0] a);
        if (a < 12'h040) return 1;
        if (a >= 12'h200 && a < 12'h240) return 2;
        return 0;
    endfunction

    function automatic int decode_idx(logic [11:0] a);
        if (a < 12'h040) return int'(a >> 3);
        return int'((a - 12'h200) >> 3);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_cpu[i] = '0;
            m_vec[i] = '0;
        end
        m_mask = '1;
        m_pend = '0;
        m_req  = '0;
    endtask

    // predict one clock from the present inputs, then compare after the edge
    task automatic cycle();
        logic        e_rv, e_err, e_pv;
        logic [63:0] e_rd;
        logic [4:0]  e_pc;
        logic [5:0]  e_pvec;
        logic [7:0]  acc, pool, grant;
        int          kind, idx;
        e_rv = req_valid;
        e_err = 1'b0;
        e_rd = '0;
        kind = decode_kind(req_addr);
        idx = decode_idx(req_addr);
        if (req_valid) begin
            if (kind == 0) e_err = 1'b1;
            else if (!req_write && kind == 1)
                e_rd = {51'd0, m_cpu[idx], 2'b00, m_vec[idx]};
            else if (!req_write && kind == 2)
                e_rd = {61'd0, m_mask[idx], 1'b0, m_pend[idx]};
        end
        acc = dev_irq & ~m_mask;
        pool = m_req | acc;
        grant = '0;
        e_pv = 1'b0;
        e_pc = '0;
        e_pvec = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (pool[i]) begin
                grant = 8'(1 << i);
                e_pv = 1'b1;
                e_pc = m_cpu[i];
                e_pvec = m_vec[i];
            end
        end
        if (req_valid && req_write && kind == 1) begin
            m_cpu[idx] = req_wdata[12:8];
            m_vec[idx] = req_wdata[5:0];
        end
        if (req_valid && req_write && kind == 2) begin
            m_mask[idx] = req_wdata[2];
            if (req_wdata[1]) m_pend[idx] = 1'b0;
        end
        m_mask = m_mask | acc;
        m_pend = m_pend | acc;
        m_req = pool & ~grant;
        @(posedge clk);
        #2;
        check("R10", "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        check("R9", "rsp_err", 64'(rsp_err), 64'(e_err));
        if (e_rv) check(cur_tag, "rsp_rdata", rsp_rdata, e_rd);
        check(cur_tag, "post_valid", 64'(post_valid), 64'(e_pv));
        if (e_pv) begin
            check(cur_tag, "post_cpu", 64'(post_cpu), 64'(e_pc));
            check(cur_tag, "post_vec", 64'(post_vec), 64'(e_pvec));
        end
    endtask

    task automatic access(logic wr, logic [11:0] a, logic [63:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr = a;
        req_wdata = d;
        cycle();
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic fire(logic [7:0] v);
        dev_irq = v;
        cycle();
        dev_irq = '0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R1: reset contents
        cur_tag = "R1";
        for (int i = 0; i < NS; i++) begin
            access(1'b0, 12'(i * 8), '0);
            check("R1", "route reset", rsp_rdata, 64'h0);
            access(1'b0, 12'(12'h200 + i * 8), '0);
            check("R1", "ctrl reset", rsp_rdata, 64'h4);
        end

        // R2: routing fields, upper bits dropped
        cur_tag = "R2";
        access(1'b1, 12'h010, 64'hFFFF_FFFF_FFFF_FFFF);
        access(1'b0, 12'h010, '0);
        check("R2", "route all ones", rsp_rdata, 64'h1F3F);
        access(1'b1, 12'h018, 64'h0000_0000_0000_0A15);
        access(1'b0, 12'h018, '0);

        // R8: low address bits ignored, stride of eight bytes
        cur_tag = "R8";
        access(1'b1, 12'h03D, 64'h0000_0000_0000_1C2A);
        access(1'b0, 12'h038, '0);
        check("R8", "route idx 7", rsp_rdata, 64'h1C2A);
        access(1'b0, 12'h030, '0);
        check("R8", "route idx 6 untouched", rsp_rdata, 64'h0);

        // R3 and R4: control write and clear
        cur_tag = "R3";
        access(1'b1, 12'h208, 64'h0);
        access(1'b0, 12'h208, '0);
        check("R3", "mask cleared", rsp_rdata, 64'h0);
        cur_tag = "R6";
        access(1'b1, 12'h008, 64'h0000_0000_0000_0305);
        fire(8'h02);
        idle(1);
        cur_tag = "R4";
        access(1'b0, 12'h208, '0);
        check("R4", "armed after accept", rsp_rdata, 64'h5);
        access(1'b1, 12'h208, 64'h4);
        access(1'b0, 12'h208, '0);
        check("R4", "bit1 zero keeps pending", rsp_rdata, 64'h5);
        access(1'b1, 12'h208, 64'h6);
        access(1'b0, 12'h208, '0);
        check("R4", "bit1 one clears pending", rsp_rdata, 64'h4);

        // R5: masked source ignored
        cur_tag = "R5";
        fire(8'h02);
        cycle();
        check("R5", "no post", 64'(post_valid), 64'h0);
        access(1'b0, 12'h208, '0);
        check("R5", "pending untouched", rsp_rdata, 64'h4);

        // R7: simultaneous sources, ascending order
        cur_tag = "R7";
        access(1'b1, 12'h020, 64'h0000_0000_0000_0411);
        access(1'b1, 12'h030, 64'h0000_0000_0000_0622);
        access(1'b1, 12'h208, 64'h2);
        access(1'b1, 12'h220, 64'h2);
        access(1'b1, 12'h230, 64'h2);
        fire(8'h52);
        fire(8'h00);
        idle(3);

        // R11: acceptance beats a same-cycle control write
        cur_tag = "R11";
        access(1'b1, 12'h218, 64'h0);
        dev_irq = 8'h08;
        access(1'b1, 12'h218, 64'h2);
        dev_irq = '0;
        idle(1);
        access(1'b0, 12'h218, '0);
        check("R11", "accept wins", rsp_rdata, 64'h5);

        // R9: unmapped offsets
        cur_tag = "R9";
        access(1'b1, 12'h100, 64'hFFFF);
        check("R9", "write err", 64'(rsp_err), 64'h1);
        access(1'b0, 12'h240, '0);
        check("R9", "read data", rsp_rdata, 64'h0);
        access(1'b0, 12'h040, '0);

        // R6/R7 random mix
        cur_tag = "R6 random";
        for (int n = 0; n < 4000; n++) begin
            int r;
            dev_irq = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
            r = int'($urandom % 10);
            if (($urandom % 2) == 0) begin
                req_valid = 1'b1;
                req_write = 1'($urandom);
                if (r < 4) req_addr = 12'(($urandom % 8) * 8 + ($urandom % 8));
                else if (r < 8) req_addr = 12'(12'h200 + ($urandom % 8) * 8 + ($urandom % 8));
                else req_addr = 12'($urandom);
                req_wdata = {$urandom, $urandom};
                if (r >= 4 && r < 8 && ($urandom % 4) != 0) req_wdata[2] = 1'b0;
            end
            cycle();
            req_valid = 1'b0;
            req_write = 1'b0;
            dev_irq = '0;
        end
        cur_tag = "R7 drain";
        idle(10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule